// File: doc/BRIEF.md
# Mode-selectable signed/unsigned multiplier

This block multiplies two N-bit operands and returns the full 2N-bit product. A single mode input chooses whether the operands are treated as plain binary magnitudes or as two's complement values. Both interpretations run through the same signed datapath.

Each operand is first widened by one bit. In signed mode the new top bit copies the sign, and in unsigned mode it is cleared. The multiplicand is spread into one shifted row for each low multiplier bit, and those rows are added with plain modular addition. The row that belongs to the widened multiplier's top bit is then taken away by inverting it and adding one. The raw sum is one bit wider than the product, and that surplus top bit is discarded.

The product is captured in one register stage, so a result appears on the clock edge after its operands are sampled. Reset is asynchronous and active low.

Top module: `dualmode_mult`

## Requirements
- R1: With signed_mode = 1, bit N of each widened operand equals that operand's bit N-1.
- R2: With signed_mode = 0, bit N of each widened operand is 0, so an operand with bit N-1 set is read as a positive magnitude (unsigned 0x8000 × 2 gives 0x00010000 at N = 16).
- R3: product equals a × b, interpreted in the selected mode and reduced to 2N bits. It is valid on the rising edge after a, b and signed_mode are sampled.
- R4: When the widened multiplier's top bit is 1, its row is subtracted rather than added (signed 0x0001 × 0xFFFF gives 0xFFFFFFFF at N = 16).
- R5: The raw (2N+1)-bit sum has a top bit that equals bit 2N-1 in signed mode and is 0 in unsigned mode. The product drops it.
- R6: With N = 4, signed 0111 × 1000 gives 11001000 and unsigned 0111 × 1100 gives 01010100. With N = 8, signed 0x80 × 0x80 gives 0x4000.
- R7: The largest unsigned operands give the full-width product: 255 × 255 = 0xFE01 at N = 8, and 0xFFFF × 0xFFFF = 0xFFFE0001 at N = 16.
- R8: While rst_n is 0, product is 0.
- R9: A zero on either operand gives a product of 0 in either mode.
- R10: When the widened multiplier's top bit is 0, the subtracted row is zero and contributes nothing.
- R11: In signed mode with both operands nonzero, product bit 2N-1 equals the XOR of the operands' sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the product register |
| rst_n | input | 1 | Asynchronous active-low reset |
| a | input | N | Multiplicand |
| b | input | N | Multiplier |
| signed_mode | input | 1 | 1 = two's complement operands, 0 = unsigned |
| product | output | 2N | Registered full-width product |

## Verification
The hardest cases to reach are those where the subtracted row and the widened sign bits interact at the extremes. Examples are the most negative value times itself, a negative multiplier against a positive multiplicand, and unsigned operands whose top bit would read as negative in signed mode. Random operands seldom land on these patterns. The stimulus therefore drives them as directed vectors in both modes at N = 16, and at N = 4 and N = 8 on separate instances, before a long random run in which the mode toggles. Every cycle is compared against a reference model that multiplies integers behaviourally.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic {
    MODE_UNSIGNED = 1'b0,
    MODE_SIGNED   = 1'b1
  } dm_mode_e;

  // Value placed in the added top bit of a widened operand.
  function automatic logic ext_fill(input dm_mode_e mode, input logic msb);
    return (mode == MODE_SIGNED) ? msb : 1'b0;
  endfunction
endpackage

// File: rtl/dm_operand_ext.sv
module dm_operand_ext
  import dm_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         mode,
  input  logic [N-1:0] x,
  output logic [N:0]   x_ext
);
  assign x_ext = {ext_fill(dm_mode_e'(mode), x[N-1]), x};
endmodule

// File: rtl/dm_row_bank.sv
module dm_row_bank #(
  parameter int N = 16
) (
  input  logic [N:0]              a_ext,
  input  logic [N:0]              b_ext,
  output logic [N-1:0][2*N:0]     add_rows,
  output logic [2*N:0]            sub_row
);
  localparam int RW = 2 * N + 1;

  logic [RW-1:0] a_full;
  assign a_full = {{N{a_ext[N]}}, a_ext};

  for (genvar i = 0; i < N; i++) begin : g_row
    assign add_rows[i] = b_ext[i] ? (a_full << i) : '0;
  end

  assign sub_row = b_ext[N] ? (a_full << N) : '0;
endmodule

// File: rtl/dm_row_sum.sv
module dm_row_sum #(
  parameter int N = 16
) (
  input  logic [N-1:0][2*N:0] add_rows,
  input  logic [2*N:0]        sub_row,
  output logic [2*N:0]        raw
);
  localparam int RW = 2 * N + 1;
  localparam logic [RW-1:0] ONE = {{(RW-1){1'b0}}, 1'b1};

  function automatic logic [RW-1:0] negate(input logic [RW-1:0] v);
    return ~v + ONE;
  endfunction

  logic [RW-1:0] acc [0:N];
  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_acc
    assign acc[i+1] = acc[i] + add_rows[i];
  end

  assign raw = acc[N] + negate(sub_row);
endmodule

// File: rtl/dualmode_mult.sv
module dualmode_mult #(
  parameter int N = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  input  logic           signed_mode,
  output logic [2*N-1:0] product
);
  logic [N:0]           a_ext;
  logic [N:0]           b_ext;
  logic [N-1:0][2*N:0]  add_rows;
  logic [2*N:0]         sub_row;
  logic [2*N:0]         raw;
  logic                 raw_top;
  logic                 raw_msb;

  dm_operand_ext #(.N(N)) u_ext_a (.mode(signed_mode), .x(a), .x_ext(a_ext));
  dm_operand_ext #(.N(N)) u_ext_b (.mode(signed_mode), .x(b), .x_ext(b_ext));

  dm_row_bank #(.N(N)) u_rows (
    .a_ext(a_ext), .b_ext(b_ext), .add_rows(add_rows), .sub_row(sub_row)
  );

  dm_row_sum #(.N(N)) u_sum (
    .add_rows(add_rows), .sub_row(sub_row), .raw(raw)
  );

  assign raw_top = raw[2*N];
  assign raw_msb = raw[2*N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) product <= '0;
    else        product <= raw[2*N-1:0];
  end
endmodule

// File: rtl/dm_checker.sv
module dm_checker #(
  parameter int N = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           signed_mode,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic [N:0]     a_ext,
  input logic [N:0]     b_ext,
  input logic [2*N:0]   sub_row,
  input logic           raw_top,
  input logic           raw_msb,
  input logic [2*N-1:0] product
);
  // R1
  ext_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    signed_mode |-> (a_ext[N] == a[N-1]) && (b_ext[N] == b[N-1]));

  // R2
  ext_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !signed_mode |-> !a_ext[N] && !b_ext[N]);

  // R10
  sub_row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_ext[N] |-> (sub_row == '0));

  // R5
  raw_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw_top == (signed_mode ? raw_msb : 1'b0));

  // R9
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((a == '0) || (b == '0)) |=> (product == '0));

  // R11
  signed_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (signed_mode && (a != '0) && (b != '0))
      |=> (product[2*N-1] == ($past(a[N-1]) ^ $past(b[N-1]))));
endmodule

bind dualmode_mult dm_checker #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .signed_mode(signed_mode), .a(a), .b(b),
  .a_ext(a_ext), .b_ext(b_ext), .sub_row(sub_row),
  .raw_top(raw_top), .raw_msb(raw_msb), .product(product)
);

// File: tb/dualmode_mult_test.sv
`timescale 1ns/1ps
module dualmode_mult_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]   a16 = '0, b16 = '0;
  logic           m16 = 1'b0;
  logic [2*N-1:0] p16;
  logic [7:0]     a8 = '0, b8 = '0;
  logic           m8 = 1'b0;
  logic [15:0]    p8;
  logic [3:0]     a4 = '0, b4 = '0;
  logic           m4 = 1'b0;
  logic [7:0]     p4;

  dualmode_mult #(.N(N)) uut (.clk(clk), .rst_n(rst_n), .a(a16), .b(b16),
                              .signed_mode(m16), .product(p16));
  dualmode_mult #(.N(8)) uut_n8 (.clk(clk), .rst_n(rst_n), .a(a8), .b(b8),
                                 .signed_mode(m8), .product(p8));
  dualmode_mult #(.N(4)) uut_n4 (.clk(clk), .rst_n(rst_n), .a(a4), .b(b4),
                                 .signed_mode(m4), .product(p4));

  int compared = 0;
  int mismatched = 0;
  string tag = "R3";
  bit live = 1'b0;

  function automatic logic [31:0] model16(logic [15:0] x, logic [15:0] y, logic s);
    longint xi = s ? longint'($signed(x)) : longint'(x);
    longint yi = s ? longint'($signed(y)) : longint'(y);
    longint pr = xi * yi;
    return pr[31:0];
  endfunction

  task automatic check(input bit ok, input string t, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", t, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison of the N=16 instance.
  logic [31:0] exp_q;
  string       tag_q;
  bit          valid_q = 1'b0;
  always @(posedge clk) begin
    exp_q   <= model16(a16, b16, m16);
    tag_q   <= tag;
    valid_q <= live;
  end
  always @(negedge clk) begin
    if (valid_q) check(p16 == exp_q, tag_q, longint'(p16), longint'(exp_q));
  end

  task automatic vec16(input logic [15:0] x, input logic [15:0] y, input logic s, input string t);
    @(negedge clk);
    a16 = x; b16 = y; m16 = s; tag = t;
  endtask

  task automatic vec8(input logic [7:0] x, input logic [7:0] y, input logic s,
                      input logic [15:0] exp, input string t);
    @(negedge clk);
    a8 = x; b8 = y; m8 = s;
    @(negedge clk);
    check(p8 == exp, t, longint'(p8), longint'(exp));
  endtask

  task automatic vec4(input logic [3:0] x, input logic [3:0] y, input logic s,
                      input logic [7:0] exp, input string t);
    @(negedge clk);
    a4 = x; b4 = y; m4 = s;
    @(negedge clk);
    check(p4 == exp, t, longint'(p4), longint'(exp));
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    a16 = 16'h1234; b16 = 16'h5678; m16 = 1'b1;
    a8 = 8'h33; b8 = 8'h44; a4 = 4'h5; b4 = 4'h6;
    repeat (3) @(negedge clk);
    // R8: held in reset, every product reads zero
    check(p16 == '0, "R8", longint'(p16), 0);
    check(p8 == '0, "R8", longint'(p8), 0);
    check(p4 == '0, "R8", longint'(p4), 0);
    rst_n = 1'b1;
    live = 1'b1;

    // R9: zero operand in both modes
    vec16(16'h0000, 16'hFFFF, 1'b1, "R9");
    vec16(16'h8000, 16'h0000, 1'b0, "R9");
    // R1: sign extension in signed mode
    vec16(16'hFFFF, 16'h0001, 1'b1, "R1");
    vec16(16'h8000, 16'h7FFF, 1'b1, "R1");
    // R2: top bit read as magnitude in unsigned mode
    vec16(16'h8000, 16'h0002, 1'b0, "R2");
    vec16(16'hFFFF, 16'h0001, 1'b0, "R2");
    // R4: subtracted row when multiplier sign is set
    vec16(16'h0001, 16'hFFFF, 1'b1, "R4");
    vec16(16'h7FFF, 16'h8000, 1'b1, "R4");
    // R10: multiplier sign clear, no subtraction
    vec16(16'hFFFF, 16'h7FFF, 1'b1, "R10");
    // R5/R11: extreme signed corner, top bit must be dropped cleanly
    vec16(16'h8000, 16'h8000, 1'b1, "R5");
    vec16(16'h8001, 16'h7FFF, 1'b1, "R11");
    // R7: largest unsigned operands
    vec16(16'hFFFF, 16'hFFFF, 1'b0, "R7");

    // R6 and R7 at small widths
    vec4(4'b0111, 4'b1000, 1'b1, 8'b1100_1000, "R6");
    vec4(4'b0111, 4'b1100, 1'b0, 8'b0101_0100, "R6");
    vec8(8'h80, 8'h80, 1'b1, 16'h4000, "R6");
    vec8(8'hFF, 8'hFF, 1'b0, 16'hFE01, "R7");
    vec8(8'hFF, 8'hFF, 1'b1, 16'h0001, "R4");

    // R3: random operands, mode toggling
    for (int k = 0; k < 400; k++) begin
      vec16(16'($urandom), 16'($urandom), 1'($urandom), "R3");
    end

    repeat (3) @(negedge clk);
    live = 1'b0;
    @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule